// File: doc/BRIEF.md
# Function Block Clock Conditioner

This block picks the clock for one configurable digital function block out of sixteen candidate sources. The candidates are the base system clock, the double-rate system clock, three divided clocks, comparator lines, row inputs and the outputs of neighbouring blocks. A 2-bit mode then decides what the downstream block receives:

- In either of two resynchronizing modes, each rising edge of the chosen source becomes a one-cycle clock-enable strobe. The strobe lives in the base domain or in the double-rate domain, depending on the mode.
- In a third mode the select is disregarded and the base system clock itself is handed out.
- In the fourth mode the chosen source is passed through untouched. This lets the block keep counting from an external clock while the system clocks are halted.

Nothing in this block carries a data stream. The enable is a single-cycle strobe with no back-pressure: the consumer must act on it in the cycle it is high. The select and mode are quasi-static control. Changing either one clears the resynchronizers and opens a short blanking window, so the switch itself never looks like a clock edge.

Top module: `blkclk_cond`

## Requirements
- R1: The source used is bit `src_sel` of `src_vec` (index equals the select value). Activity on the other fifteen bits never produces a strobe.
- R2: `sync_mode` encoding is 0 for base-domain resync, 1 for double-rate resync, 2 for direct system clock and 3 for raw pass-through. `en_domain` is 1 exactly when `sync_mode` is 1.
- R3: In mode 0, each rising edge of the chosen source gives one `blk_en` strobe, and that strobe is one `clk_sys` cycle wide. If the source rises before `clk_sys` edge k, `blk_en` is high between edges k+2 and k+3 and low between edges k+1 and k+2.
- R4: Mode 1 behaves as R3, with every cycle and edge counted on `clk_sys2`.
- R5: In mode 2, `raw_clk` follows `clk_sys` whatever `src_sel` and `src_vec` hold, and `blk_en` stays 0.
- R6: In mode 3, `raw_clk` equals `src_vec[src_sel]` combinationally, and `blk_en` stays 0.
- R7: In modes 0 and 1, `raw_clk` is held at 0.
- R8: After any change of `src_sel` or `sync_mode`, no strobe is produced for the following three target-domain cycles, even if the new source is already high. A true rising edge after that window produces a strobe.
- R9: `rst` (synchronous, active high, sampled in both domains) clears every flop. `blk_en` is 0 throughout reset. A source that is already high when reset is released produces no strobe.
- R10: `blk_en` is never high in two consecutive target-domain cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Base system clock |
| clk_sys2 | input | 1 | Double-rate system clock |
| rst | input | 1 | Synchronous active-high reset |
| src_vec | input | 16 | Candidate clock sources |
| src_sel | input | 4 | Index of the chosen source |
| sync_mode | input | 2 | Conditioning mode (0 base, 1 double, 2 direct, 3 raw) |
| blk_en | output | 1 | One-cycle enable strobe per source rising edge |
| en_domain | output | 1 | 1 when `blk_en` belongs to the double-rate domain |
| raw_clk | output | 1 | Bypass clock in direct and raw modes, else 0 |

## Verification
Two functions can fall in the same cycle: the blanking that follows a select or mode change, and edge detection of a source that is already high. The bench provokes this by switching the select from one high source to another high source, and by moving from base to double-rate mode while the source is held high. It requires zero strobes over the next eight target cycles, then exactly one strobe once a genuine low-to-high transition follows. A similar collision at reset release, with the source high, is judged the same way.

// File: rtl/blkclk_pkg.sv
`timescale 1ns/1ps
package blkclk_pkg;
  typedef enum logic [1:0] {
    MODE_SYS    = 2'd0,
    MODE_SYS2   = 2'd1,
    MODE_DIRECT = 2'd2,
    MODE_RAW    = 2'd3
  } sync_mode_e;

  localparam int NUM_DOMAINS = 2;
endpackage

// File: rtl/src_mux.sv
`timescale 1ns/1ps
module src_mux #(
  parameter int NUM_SRC = 16,
  localparam int SEL_W = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0] vec,
  input  logic [SEL_W-1:0]   sel,
  output logic               chosen
);
  always_comb begin
    chosen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (sel == SEL_W'(i)) chosen = vec[i];
    end
  end
endmodule

// File: rtl/edge_resync.sv
`timescale 1ns/1ps
module edge_resync #(
  parameter int STAGES = 2,
  parameter int CFG_W  = 6,
  localparam int BLANK = STAGES + 1,
  localparam int BW    = $clog2(BLANK + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CFG_W-1:0] cfg,
  input  logic             src_in,
  output logic             pulse
);
  logic [STAGES-1:0] sh;
  logic              prev;
  logic [BW-1:0]     blank;
  logic [CFG_W-1:0]  cfg_q;
  logic              cfg_chg, clr, rise;

  assign cfg_chg = (cfg != cfg_q);
  assign clr     = rst | ~active | cfg_chg;
  assign rise    = sh[STAGES-1] & ~prev & (blank == '0);

  always_ff @(posedge clk) begin
    cfg_q <= cfg;
    if (clr) begin
      sh    <= '0;
      prev  <= 1'b0;
      blank <= BW'(BLANK);
      pulse <= 1'b0;
    end else begin
      sh    <= {sh[STAGES-2:0], src_in};
      prev  <= sh[STAGES-1];
      if (blank != '0) blank <= blank - 1'b1;
      pulse <= rise;
    end
  end

  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  // R8
  switch_blank_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_chg |=> !pulse);

  // R9
  reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !pulse);
endmodule

// File: rtl/blkclk_cond.sv
`timescale 1ns/1ps
module blkclk_cond
  import blkclk_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int STAGES  = 2,
  localparam int SEL_W  = $clog2(NUM_SRC),
  localparam int CFG_W  = SEL_W + 2
) (
  input  logic               clk_sys,
  input  logic               clk_sys2,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_vec,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [1:0]         sync_mode,
  output logic               blk_en,
  output logic               en_domain,
  output logic               raw_clk
);
  logic                   chosen;
  logic [NUM_DOMAINS-1:0] dom_clk;
  logic [NUM_DOMAINS-1:0] dom_pulse;
  logic [CFG_W-1:0]       cfg;
  sync_mode_e             mode;

  assign mode    = sync_mode_e'(sync_mode);
  assign cfg     = {sync_mode, src_sel};
  assign dom_clk = {clk_sys2, clk_sys};

  src_mux #(.NUM_SRC(NUM_SRC)) u_mux (
    .vec    (src_vec),
    .sel    (src_sel),
    .chosen (chosen)
  );

  for (genvar g = 0; g < NUM_DOMAINS; g++) begin : g_dom
    edge_resync #(.STAGES(STAGES), .CFG_W(CFG_W)) u_sync (
      .clk    (dom_clk[g]),
      .rst    (rst),
      .active (sync_mode == 2'(g)),
      .cfg    (cfg),
      .src_in (chosen),
      .pulse  (dom_pulse[g])
    );
  end

  always_comb begin
    blk_en  = 1'b0;
    raw_clk = 1'b0;
    unique case (mode)
      MODE_SYS:    blk_en  = dom_pulse[0];
      MODE_SYS2:   blk_en  = dom_pulse[1];
      MODE_DIRECT: raw_clk = clk_sys;
      MODE_RAW:    raw_clk = chosen;
      default:     blk_en  = 1'b0;
    endcase
  end

  assign en_domain = (mode == MODE_SYS2);

  // R3 R4: the two domain strobes never overlap
  one_domain_chk: assert property (@(posedge clk_sys2) disable iff (rst)
    !(dom_pulse[0] && dom_pulse[1]));
endmodule

// File: tb/blkclk_cond_test.sv
`timescale 1ns/1ps
module blkclk_cond_test;
  localparam real CLK_PERIOD = 10.0;

  logic        clk_sys = 1'b0, clk_sys2 = 1'b0, rst = 1'b1;
  logic [15:0] src_vec = '0;
  logic [3:0]  src_sel = '0;
  logic [1:0]  sync_mode = '0;
  logic        blk_en, en_domain, raw_clk;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  blkclk_cond uut (
    .clk_sys(clk_sys), .clk_sys2(clk_sys2), .rst(rst), .src_vec(src_vec),
    .src_sel(src_sel), .sync_mode(sync_mode), .blk_en(blk_en),
    .en_domain(en_domain), .raw_clk(raw_clk)
  );

  initial forever #(CLK_PERIOD / 2.0) clk_sys = ~clk_sys;
  initial begin
    #(CLK_PERIOD / 8.0);
    forever #(CLK_PERIOD / 4.0) clk_sys2 = ~clk_sys2;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tgt_neg(input int m);
    if (m == 1) @(negedge clk_sys2);
    else @(negedge clk_sys);
  endtask

  task automatic set_cfg(input int m, input int s);
    @(negedge clk_sys);
    sync_mode = 2'(m);
    src_sel   = 4'(s);
    src_vec   = '0;
  endtask

  task automatic sweep_one(input int m, input int s);
    logic [3:0]  pat;
    logic [15:0] noise;
    int          cnt, runs;
    bit          last, lvl;
    string       rq;
    rq = (m == 1) ? "R4" : "R3";
    set_cfg(m, s);
    repeat (6) tgt_neg(m);
    check(en_domain == (m == 1), "R2", "en_domain", en_domain, m == 1);
    check(raw_clk == 1'b0, "R7", "raw_clk in resync mode", raw_clk, 0);
    // latency: source rises before edge k, strobe after edge k+2
    tgt_neg(m);
    src_vec[s] = 1'b1;
    for (int i = 0; i < 4; i++) begin
      tgt_neg(m);
      pat[i] = blk_en;
    end
    check(pat == 4'b0100, rq, $sformatf("latency pattern sel=%0d", s), pat, 4);
    repeat (4) tgt_neg(m);
    src_vec[s] = 1'b0;
    repeat (4) tgt_neg(m);
    // count strobes with other sources toggling (R1)
    cnt = 0; runs = 0; last = 0; noise = 16'h5A3C;
    for (int e = 0; e < 4; e++) begin
      for (int c = 0; c < 8; c++) begin
        tgt_neg(m);
        if (blk_en) cnt++;
        if (blk_en && last) runs++;
        last = blk_en;
        lvl = (e < 3) && (c < 4);
        noise = ~noise;
        src_vec = noise;
        src_vec[s] = lvl;
      end
    end
    check(cnt == 3, "R1", $sformatf("%s strobe count sel=%0d", rq, s), cnt, 3);
    check(runs == 0, "R10", "back-to-back strobes", runs, 0);
  endtask

  initial begin
    int cnt;
    bit bad;
    // reset with toggling source
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_sys);
      src_vec = {16{i[0]}};
      if (blk_en !== 1'b0) bad = 1;
    end
    check(!bad, "R9", "blk_en during reset", bad, 0);
    check(en_domain == 1'b0, "R2", "en_domain mode 0 at reset", en_domain, 0);
    // release reset with selected source high
    src_vec = 16'h0001;
    @(negedge clk_sys); rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_sys);
      if (blk_en) cnt++;
    end
    check(cnt == 0, "R9", "no strobe for high source at reset exit", cnt, 0);

    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 16; s++) sweep_one(m, s);

    // R8: switch select between two high sources
    set_cfg(0, 3);
    src_vec = 16'h0208;
    repeat (8) @(negedge clk_sys);
    src_sel = 4'd9;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_sys);
      if (blk_en) cnt++;
    end
    check(cnt == 0, "R8", "select switch onto high source", cnt, 0);
    src_vec[9] = 1'b0;
    repeat (4) @(negedge clk_sys);
    src_vec[9] = 1'b1;
    cnt = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_sys);
      if (blk_en) cnt++;
    end
    check(cnt == 1, "R8", "true edge after switch", cnt, 1);
    // R8: mode switch 0 -> 1 with source high
    sync_mode = 2'd1;
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_sys2);
      if (blk_en) cnt++;
    end
    check(cnt == 0, "R8", "mode switch with high source", cnt, 0);
    check(en_domain == 1'b1, "R2", "en_domain mode 1", en_domain, 1);

    // R5: direct mode
    bad = 0; cnt = 0;
    for (int s = 0; s < 16; s++) begin
      set_cfg(2, s);
      for (int k = 0; k < 4; k++) begin
        src_vec = 16'(k[0] ? 16'hFFFF : 16'h0000);
        #(CLK_PERIOD / 5.0);
        if (raw_clk !== clk_sys) bad = 1;
        if (blk_en !== 1'b0) cnt++;
        @(posedge clk_sys);
        #(CLK_PERIOD / 5.0);
        if (raw_clk !== clk_sys) bad = 1;
        if (blk_en !== 1'b0) cnt++;
      end
    end
    check(!bad, "R5", "raw_clk follows clk_sys", bad, 0);
    check(cnt == 0, "R5", "blk_en in direct mode", cnt, 0);
    check(en_domain == 1'b0, "R2", "en_domain mode 2", en_domain, 0);

    // R6: raw pass-through
    bad = 0; cnt = 0;
    for (int s = 0; s < 16; s++) begin
      set_cfg(3, s);
      for (int v = 0; v < 2; v++) begin
        src_vec = (v == 1) ? (16'h1 << s) : ~(16'h1 << s);
        #1;
        if (raw_clk !== v[0]) bad = 1;
        if (blk_en !== 1'b0) cnt++;
        repeat (3) @(negedge clk_sys);
        if (blk_en !== 1'b0) cnt++;
      end
    end
    check(!bad, "R6", "raw_clk equals chosen source", bad, 0);
    check(cnt == 0, "R6", "blk_en in raw mode", cnt, 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule